// File: doc/BRIEF.md
# Shared Peripheral Interrupt Controller (single CPU)

This block collects a bank of peripheral interrupt lines and delivers one interrupt request to a single processor. Each line is numbered `n` and carries the interrupt ID `n+32`. A rising edge on a line latches that line's pending bit. The register file holds three kinds of per-ID state: enable bits, pending bits and a CPU target byte. It also holds a distributor-wide enable, a CPU-side enable and a priority mask. Every interrupt has one fixed priority, `FIXED_PRIO`.

Software first routes a line to CPU0 and enables it. It then turns on both global enables and opens the priority mask. When the request output goes high, software reads the acknowledge register to get the winning ID. That read moves the ID from pending to active. Software runs its handler and then writes the same ID to the end-of-interrupt register. If several IDs are pending and eligible at once, the lowest ID wins. Only one interrupt can be active at a time, and the request output stays low while it is active.

Register byte offsets:

| Offset | Register |
|---|---|
| 0x00 | distributor control |
| 0x04 | CPU control |
| 0x08 | priority mask |
| 0x0C | acknowledge |
| 0x10 | end-of-interrupt |
| 0x40 + 4·w | set-enable word w |
| 0x60 + 4·w | pending / clear-pending word w |
| 0x80 + 4·t | target word t |

Reads have no side effect, except a read of the acknowledge register. Read data is combinational and valid in the cycle the read strobe is high.

Top module: `shared_irq_ctrl`

## Requirements
- R1: After reset, every register reads zero, `irq_out` is low and an acknowledge read returns 1023.
- R2: The enable bit of ID `n+32` is bit `(n+32)%32` of set-enable word `(n+32)/32`. Writing 1 there sets the bit, writing 0 leaves it unchanged, and the word reads back the stored enables. For example, line 25 is ID 57: word 1, bit 25.
- R3: A rising edge on line `n` sets the pending bit of ID `n+32` at the first clock edge that samples the line high, whether or not the ID is enabled. The pending bit reads back at the same word and bit position as its enable bit.
- R4: Writing 1 to a pending-word bit clears that pending bit. Writing 0 leaves it unchanged.
- R5: The target byte of an ID is byte `ID%4` of target word `ID/4`, and it reads back as written. An ID is forwarded only when bit 0 of its target byte (CPU0) is set.
- R6: `irq_out` can be high only when bit 0 of the distributor control register and bit 0 of the CPU control register are both 1.
- R7: An ID is forwarded only when the priority mask is numerically greater than `FIXED_PRIO` (default 0x80). A mask of 0xFF passes every ID, and a mask of 0x80 blocks every ID.
- R8: `irq_out` is high when some pending, enabled, CPU0-routed ID passes the gates of R6 and R7 and no ID is active. An acknowledge read then returns the lowest such ID in bits [8:0], with bits [31:9] zero. The read clears that ID's pending bit, makes the ID active and holds `irq_out` low.
- R9: When no ID can be acknowledged, because none is eligible or one is already active, an acknowledge read returns 1023 and changes no state.
- R10: Writing the active ID into bits [8:0] of the end-of-interrupt register ends the active state. A write carrying any other ID is ignored.
- R11: If a rising edge on a line falls in the same cycle as an acknowledge or a clear-pending write for that line's ID, the pending bit is left set.
- R12: A line held high does not set its pending bit again after the bit has been cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_lines | input | NLINES | Peripheral interrupt lines; line n is ID n+32 |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (needed for the acknowledge side effect) |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational |
| irq_out | output | 1 | Interrupt request to CPU0 |

## Verification
Two actions can land in the same cycle: a new rising edge on a line, and software removing that same ID's pending bit, either by an acknowledge read or by a clear-pending write. The bench drives the line edge and the register access from the same falling clock edge. It then judges the result through the normal register interface. The pending word must still show the bit. After end-of-interrupt, `irq_out` must rise again, and a second acknowledge must return the same ID.

// File: rtl/shared_irq_ctrl.sv
module shared_irq_ctrl #(
  parameter int NLINES     = 64,
  parameter int ID_BASE    = 32,
  parameter int FIXED_PRIO = 8'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] irq_lines,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [7:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq_out
);
  localparam int NID = ID_BASE + NLINES;
  localparam int LW  = (NLINES > 1) ? $clog2(NLINES) : 1;
  localparam logic [9:0] SPURIOUS = 10'd1023;
  localparam logic [7:0] A_DCTRL = 8'h00, A_CCTRL = 8'h04, A_PMR = 8'h08,
                         A_ACK = 8'h0C, A_EOI = 8'h10;

  logic              dist_en, cpu_en, act_v;
  logic [7:0]        pmr;
  logic [8:0]        act_id;
  logic [NLINES-1:0] en, pend, line_q, elig, rise;
  logic [7:0]        tgt [NLINES];
  logic              win_v, can_ack, ack_take, eoi_hit;
  logic [LW-1:0]     win_idx;
  logic [9:0]        ack_id;

  wire       is_seten = reg_addr[7:5] == 3'b010;
  wire       is_pend  = reg_addr[7:5] == 3'b011;
  wire       is_tgt   = reg_addr[7];
  wire [2:0] wsel     = reg_addr[4:2];
  wire [4:0] tsel     = reg_addr[6:2];

  assign rise = irq_lines & ~line_q;

  always_comb
    for (int i = 0; i < NLINES; i++) elig[i] = pend[i] & en[i] & tgt[i][0];

  always_comb begin
    win_v   = 1'b0;
    win_idx = '0;
    for (int i = NLINES - 1; i >= 0; i--)
      if (elig[i]) begin
        win_v   = 1'b1;
        win_idx = LW'(i);
      end
  end

  assign can_ack  = dist_en & cpu_en & (int'(pmr) > FIXED_PRIO) & win_v & ~act_v;
  assign irq_out  = can_ack;
  assign ack_id   = can_ack ? 10'(ID_BASE + int'(win_idx)) : SPURIOUS;
  assign ack_take = reg_rd & (reg_addr == A_ACK) & can_ack;
  assign eoi_hit  = reg_wr & (reg_addr == A_EOI) & act_v & (reg_wdata[8:0] == act_id);

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_DCTRL)      reg_rdata[0] = dist_en;
    else if (reg_addr == A_CCTRL) reg_rdata[0] = cpu_en;
    else if (reg_addr == A_PMR)   reg_rdata[7:0] = pmr;
    else if (reg_addr == A_ACK)   reg_rdata[9:0] = ack_id;
    else if (is_seten || is_pend) begin
      for (int i = 0; i < NLINES; i++)
        if (int'(wsel) == (i + ID_BASE) / 32)
          reg_rdata[(i + ID_BASE) % 32] = is_seten ? en[i] : pend[i];
    end else if (is_tgt) begin
      for (int i = 0; i < NLINES; i++)
        if (int'(tsel) == (i + ID_BASE) / 4)
          reg_rdata[((i + ID_BASE) % 4) * 8 +: 8] = tgt[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dist_en <= 1'b0;
      cpu_en  <= 1'b0;
      pmr     <= '0;
      en      <= '0;
      pend    <= '0;
      line_q  <= '0;
      act_v   <= 1'b0;
      act_id  <= '0;
      for (int i = 0; i < NLINES; i++) tgt[i] <= '0;
    end else begin
      line_q <= irq_lines;
      if (reg_wr && reg_addr == A_DCTRL) dist_en <= reg_wdata[0];
      if (reg_wr && reg_addr == A_CCTRL) cpu_en  <= reg_wdata[0];
      if (reg_wr && reg_addr == A_PMR)   pmr     <= reg_wdata[7:0];
      for (int i = 0; i < NLINES; i++) begin
        if (reg_wr && is_seten && int'(wsel) == (i + ID_BASE) / 32
            && reg_wdata[(i + ID_BASE) % 32])
          en[i] <= 1'b1;
        if (reg_wr && is_tgt && int'(tsel) == (i + ID_BASE) / 4)
          tgt[i] <= reg_wdata[((i + ID_BASE) % 4) * 8 +: 8];
        pend[i] <= rise[i] | (pend[i] &
                   ~((reg_wr && is_pend && int'(wsel) == (i + ID_BASE) / 32
                      && reg_wdata[(i + ID_BASE) % 32])
                     || (ack_take && int'(win_idx) == i)));
      end
      if (ack_take) begin
        act_v  <= 1'b1;
        act_id <= 9'(ID_BASE + int'(win_idx));
      end else if (eoi_hit) begin
        act_v <= 1'b0;
      end
    end
  end
endmodule

module shared_irq_ctrl_chk #(
  parameter int NLINES     = 64,
  parameter int ID_BASE    = 32,
  parameter int FIXED_PRIO = 8'h80
) (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic        reg_rd,
  input logic [7:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic [31:0] reg_rdata,
  input logic        irq_out,
  input logic        dist_en,
  input logic        cpu_en,
  input logic [7:0]  pmr,
  input logic        act_v,
  input logic [8:0]  act_id
);
  wire ack_rd = reg_rd && reg_addr == 8'h0C;

  a_r8_ack_silences: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && reg_rdata != 32'd1023) |=> !irq_out);
  a_r8_ack_id_range: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && reg_rdata != 32'd1023) |->
      (int'(reg_rdata) >= ID_BASE && int'(reg_rdata) < ID_BASE + NLINES));
  a_r8_active_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    act_v |-> !irq_out);
  a_r9_spurious_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && reg_rdata == 32'd1023) |-> !irq_out);
  a_r6_irq_needs_enables: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (dist_en && cpu_en));
  a_r7_mask_gates: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (int'(pmr) > FIXED_PRIO));
  a_r10_eoi_release: assert property (@(posedge clk) disable iff (!rst_n)
    (act_v && reg_wr && reg_addr == 8'h10 && reg_wdata[8:0] == act_id) |=> !act_v);
endmodule

bind shared_irq_ctrl shared_irq_ctrl_chk #(
  .NLINES(NLINES), .ID_BASE(ID_BASE), .FIXED_PRIO(FIXED_PRIO)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .irq_out(irq_out), .dist_en(dist_en), .cpu_en(cpu_en), .pmr(pmr),
  .act_v(act_v), .act_id(act_id)
);

// File: tb/shared_irq_ctrl_test.sv
`timescale 1ns/1ps
module shared_irq_ctrl_test;
  logic        clk = 0, rst_n = 0;
  logic [63:0] irq_lines = '0;
  logic        reg_wr = 0, reg_rd = 0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_out;
  int checks = 0, errors = 0;

  shared_irq_ctrl uut (.clk(clk), .rst_n(rst_n), .irq_lines(irq_lines),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out));

  always #2.5 clk = ~clk;

  localparam logic [7:0] DCTRL = 8'h00, CCTRL = 8'h04, PMR = 8'h08,
                         ACK = 8'h0C, EOI = 8'h10;
  function automatic logic [7:0] seten(int w); return 8'(8'h40 + 4*w); endfunction
  function automatic logic [7:0] pendw(int w); return 8'(8'h60 + 4*w); endfunction
  function automatic logic [7:0] tgtw(int t);  return 8'(8'h80 + 4*t); endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic pulse(int n);
    @(negedge clk); irq_lines[n] = 1;
    @(negedge clk); irq_lines[n] = 0;
  endtask

  task automatic clear_all();
    wr(pendw(1), 32'hFFFF_FFFF);
    wr(pendw(2), 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 irq", 32'(irq_out), 0);
    rd(ACK, d);      chk("R1 ack", d, 32'd1023);
    rd(seten(1), d); chk("R1 enable", d, 0);
    rd(PMR, d);      chk("R1 mask", d, 0);
  endtask

  task automatic t_map();
    logic [31:0] d;
    wr(seten(1), 32'h0200_0000);
    rd(seten(1), d); chk("R2 id57 word1 bit25", d, 32'h0200_0000);
    wr(seten(1), 32'h0);
    rd(seten(1), d); chk("R2 zero write keeps", d, 32'h0200_0000);
    rd(seten(2), d); chk("R2 word2", d, 0);
    wr(tgtw(14), 32'h0000_0100);
    rd(tgtw(14), d); chk("R5 target word14 byte1", d, 32'h0000_0100);
  endtask

  task automatic t_edge();
    logic [31:0] d;
    pulse(3);
    rd(pendw(1), d); chk("R3 unenabled id35 pends", d, 32'h0000_0008);
    pulse(40);
    rd(pendw(2), d); chk("R3 id72 word2 bit8", d, 32'h0000_0100);
    @(negedge clk); irq_lines[0] = 1;
    @(negedge clk);
    wr(pendw(1), 32'h1);
    rd(pendw(1), d); chk("R12 held level no repend", d, 32'h0000_0008);
    @(negedge clk); irq_lines[0] = 0;
  endtask

  task automatic t_clear();
    logic [31:0] d;
    wr(pendw(1), 32'h0);
    rd(pendw(1), d); chk("R4 zero write no effect", d, 32'h0000_0008);
    wr(pendw(1), 32'h8);
    rd(pendw(1), d); chk("R4 one clears", d, 0);
    clear_all();
  endtask

  task automatic t_route();
    wr(tgtw(14), 32'h0);
    wr(DCTRL, 1); wr(CCTRL, 1); wr(PMR, 32'hFF);
    pulse(25);
    chk("R5 unrouted quiet", 32'(irq_out), 0);
    wr(tgtw(14), 32'h0000_0100);
    chk("R5 routed raises", 32'(irq_out), 1);
    wr(PMR, 32'h80); chk("R7 mask 0x80 blocks", 32'(irq_out), 0);
    wr(PMR, 32'h81); chk("R7 mask 0x81 passes", 32'(irq_out), 1);
    wr(PMR, 32'hFF);
    wr(DCTRL, 0); chk("R6 dist off", 32'(irq_out), 0);
    wr(DCTRL, 1);
    wr(CCTRL, 0); chk("R6 cpu off", 32'(irq_out), 0);
    wr(CCTRL, 1); chk("R6 both on", 32'(irq_out), 1);
  endtask

  task automatic t_ack();
    logic [31:0] d;
    wr(tgtw(10), 32'h01);
    wr(seten(1), 32'h0000_0100);
    pulse(8);
    rd(ACK, d); chk("R8 lowest id40", d, 32'd40);
    chk("R8 irq low active", 32'(irq_out), 0);
    rd(pendw(1), d); chk("R8 pending moved", d, 32'h0200_0000);
    rd(ACK, d); chk("R9 ack while active", d, 32'd1023);
    rd(pendw(1), d); chk("R9 no change", d, 32'h0200_0000);
    wr(EOI, 32'd57); chk("R10 wrong id ignored", 32'(irq_out), 0);
    wr(EOI, 32'd40); chk("R10 eoi releases", 32'(irq_out), 1);
    rd(ACK, d); chk("R8 next id57", d, 32'd57);
    wr(EOI, 32'hFFFF_FE39); chk("R10 only bits 8:0", 32'(irq_out), 0);
    rd(ACK, d); chk("R9 none left", d, 32'd1023);
  endtask

  task automatic t_spur();
    logic [31:0] d;
    pulse(3);
    rd(ACK, d); chk("R9 unenabled spurious", d, 32'd1023);
    rd(pendw(1), d); chk("R9 pending kept", d, 32'h0000_0008);
    clear_all();
  endtask

  task automatic t_race();
    logic [31:0] d;
    pulse(25);
    @(negedge clk); reg_rd = 1; reg_addr = ACK; irq_lines[25] = 1;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0; irq_lines[25] = 0;
    chk("R11 ack id", d, 32'd57);
    rd(pendw(1), d); chk("R11 edge beats ack", d, 32'h0200_0000);
    wr(EOI, 32'd57); chk("R11 refires", 32'(irq_out), 1);
    rd(ACK, d); chk("R11 second ack", d, 32'd57);
    wr(EOI, 32'd57);
    pulse(25);
    @(negedge clk); reg_wr = 1; reg_addr = pendw(1); reg_wdata = 32'h0200_0000;
    irq_lines[25] = 1;
    @(negedge clk); reg_wr = 0; irq_lines[25] = 0;
    rd(pendw(1), d); chk("R11 edge beats clear", d, 32'h0200_0000);
    clear_all();
    chk("R4 irq drops", 32'(irq_out), 0);
  endtask

  initial begin
    #1_000_000;
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_map();
    t_edge();
    t_clear();
    t_route();
    t_ack();
    t_spur();
    t_race();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule